// File: doc/BRIEF.md
# Low-Power Lane State Detector

This block watches the two single-ended low-power wires of a serial display data lane on the receive side. It cleans each observed two-wire level of short glitches and times how long each level lasts. It then follows the ordered handshakes by which the transmitter announces a high-speed burst or an escape-mode sequence. When a handshake completes correctly, the block emits a one-cycle pulse that arms the downstream high-speed deserializer or the escape decoder.

The block also notices when the lane settles back into the idle level and reports this with a stop pulse. Any handshake that breaks order or timing raises a sticky error flag. The flag holds until a clean idle level has been confirmed.

The inputs are line levels that have already been synchronized to the block clock. The glitch rejection length is set at run time through an input. The minimum dwell time, expressed in clock cycles, is a parameter and must be at least 2.

Top module: `lp_lane_monitor`

## Requirements
- R1: While `rst` is high and on the cycle after it, `line_state` is 2'b11, and `hs_start`, `esc_start`, `stop_pulse` and `seq_err` are 0. After reset is released with the wires at 11, exactly one `stop_pulse` follows once Stop has been confirmed.
- R2: A new wire level `{lp_p,lp_n}` is accepted only after it has been sampled on more than `glitch_len` consecutive clock edges. A shorter excursion changes neither `line_state` nor the sequencing. With `glitch_len` = 0, a single-cycle level is accepted.
- R3: An accepted level is confirmed once it has stayed unchanged for `TLPX_CYC` cycles. With `glitch_len` = G, a level held for exactly `TLPX_CYC` cycles on the wires is confirmed, and one held for `TLPX_CYC`-1 cycles is not.
- R4: A confirmed Stop (11), then a confirmed high-speed request (01), then a confirmed Bridge (00) produces one `hs_start` pulse. The pulse is high in the cycle after clock edge G+`TLPX_CYC`, counting from the first edge that samples 00 as edge 0.
- R5: A confirmed Stop (11), then a confirmed low-power request (10), then a confirmed Bridge (00) produces one `esc_start` pulse.
- R6: Any of the following raises `seq_err`:
  - Bridge directly after Stop.
  - A request level that changes before it is confirmed.
  - A Bridge that changes before it is confirmed.
  - Any level other than Bridge following a confirmed request.
- R7: `seq_err` stays high, and no start pulse is issued, until Stop is confirmed. In the same cycle that Stop is confirmed, `seq_err` drops and `stop_pulse` rises.
- R8: After `hs_start`, low-power levels other than Stop are ignored. A confirmed Stop then gives one `stop_pulse`.
- R9: After `esc_start`, levels other than Stop are ignored, without error. A confirmed Stop then gives one `stop_pulse`.
- R10: `hs_start`, `esc_start` and `stop_pulse` each last one cycle, and no two of them are high together.
- R11: `line_state` shows the accepted wire pair `{lp_p,lp_n}`, with 11 = Stop, 01 = high-speed request, 10 = low-power request and 00 = Bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_p | input | 1 | Synchronized positive low-power wire |
| lp_n | input | 1 | Synchronized negative low-power wire |
| glitch_len | input | GW | Excursions sampled on this many edges or fewer are rejected |
| line_state | output | 2 | Accepted wire level {lp_p,lp_n} |
| hs_start | output | 1 | One-cycle pulse arming high-speed reception |
| esc_start | output | 1 | One-cycle pulse arming the escape decoder |
| stop_pulse | output | 1 | One-cycle pulse when Stop is confirmed after any other condition |
| seq_err | output | 1 | Sticky flag for a broken handshake |

## Verification
The clearing of `seq_err` and the issue of `stop_pulse` happen in the same cycle, because both are driven by confirmation of Stop after a fault. The bench provokes this by driving Bridge straight from idle and holding it, then returning the wires to 11. It then polls until the stop pulse is seen and requires `seq_err` to be low in that very sample, while having been high on every earlier sample. A second coincidence is a short glitch that arrives while a request is still being timed. The bench checks that the glitch neither restarts the dwell count nor raises an error.

// File: rtl/lpmon_pkg.sv
package lpmon_pkg;
  typedef enum logic [1:0] {
    LS_BRIDGE = 2'b00,
    LS_HSRQ   = 2'b01,
    LS_LPRQ   = 2'b10,
    LS_STOP   = 2'b11
  } lp_state_t;

  typedef enum logic [3:0] {
    SQ_WAIT, SQ_IDLE,
    SQ_HRQ, SQ_HRQ_OK, SQ_HBR, SQ_HACT,
    SQ_ERQ, SQ_ERQ_OK, SQ_EBR, SQ_EACT
  } seq_state_t;
endpackage

// File: rtl/lpmon_filter.sv
module lpmon_filter import lpmon_pkg::*; #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    raw,
  input  logic [GW-1:0] glitch_len,
  output lp_state_t     filt,
  output logic          upd,
  output logic          chg
);
  localparam int RW = GW + 1;
  localparam logic [RW-1:0] RMAX = '1;

  logic [1:0]    prev;
  logic [RW-1:0] run, run_n;

  always_comb begin
    if (raw == prev) run_n = (run == RMAX) ? run : run + 1'b1;
    else             run_n = RW'(1);
    upd = (lp_state_t'(raw) != filt) && (run_n > {1'b0, glitch_len});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 2'b11;
      run  <= '0;
      filt <= LS_STOP;
      chg  <= 1'b0;
    end else begin
      prev <= raw;
      run  <= run_n;
      chg  <= upd;
      if (upd) filt <= lp_state_t'(raw);
    end
  end

  // R2
  chg_means_new_level_chk: assert property (@(posedge clk) disable iff (rst)
    chg |-> (filt != $past(filt)));
  // R2
  level_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !chg |-> $stable(filt));
endmodule

// File: rtl/lpmon_dwell.sv
module lpmon_dwell #(
  parameter int TLPX_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  output logic conf
);
  localparam int DW = $clog2(TLPX_CYC + 1);
  localparam logic [DW-1:0] LAST = DW'(TLPX_CYC - 1);
  localparam logic [DW-1:0] SAT  = DW'(TLPX_CYC);

  logic [DW-1:0] dwell;

  always_ff @(posedge clk) begin
    if (rst)               dwell <= '0;
    else if (upd)          dwell <= '0;
    else if (dwell != SAT) dwell <= dwell + 1'b1;
  end

  assign conf = (dwell == LAST);

  // R3
  conf_once_chk: assert property (@(posedge clk) disable iff (rst)
    conf |=> !conf);
endmodule

// File: rtl/lpmon_seq.sv
module lpmon_seq import lpmon_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  lp_state_t filt,
  input  logic      chg,
  input  logic      conf,
  output logic      hs_start,
  output logic      esc_start,
  output logic      stop_pulse,
  output logic      seq_err
);
  seq_state_t st, nxt;
  logic hs_n, esc_n, stop_n, err_n;

  always_comb begin
    nxt    = st;
    hs_n   = 1'b0;
    esc_n  = 1'b0;
    stop_n = 1'b0;
    err_n  = seq_err;
    unique case (st)
      SQ_WAIT, SQ_HACT, SQ_EACT:
        if (conf && filt == LS_STOP) begin
          nxt = SQ_IDLE; stop_n = 1'b1; err_n = 1'b0;
        end
      SQ_IDLE:
        if (chg) begin
          if (filt == LS_HSRQ)      nxt = SQ_HRQ;
          else if (filt == LS_LPRQ) nxt = SQ_ERQ;
          else begin nxt = SQ_WAIT; err_n = 1'b1; end
        end
      SQ_HRQ, SQ_ERQ:
        if (conf)     nxt = (st == SQ_HRQ) ? SQ_HRQ_OK : SQ_ERQ_OK;
        else if (chg) begin nxt = SQ_WAIT; err_n = 1'b1; end
      SQ_HRQ_OK, SQ_ERQ_OK:
        if (chg) begin
          if (filt == LS_BRIDGE) nxt = (st == SQ_HRQ_OK) ? SQ_HBR : SQ_EBR;
          else begin nxt = SQ_WAIT; err_n = 1'b1; end
        end
      SQ_HBR, SQ_EBR:
        if (conf) begin
          if (st == SQ_HBR) begin nxt = SQ_HACT; hs_n  = 1'b1; end
          else              begin nxt = SQ_EACT; esc_n = 1'b1; end
        end else if (chg) begin
          nxt = SQ_WAIT; err_n = 1'b1;
        end
      default: nxt = SQ_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_WAIT;
      hs_start <= 1'b0; esc_start <= 1'b0; stop_pulse <= 1'b0; seq_err <= 1'b0;
    end else begin
      st <= nxt;
      hs_start <= hs_n; esc_start <= esc_n; stop_pulse <= stop_n; seq_err <= err_n;
    end
  end

  // R10
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hs_start, esc_start, stop_pulse}));
  // R10
  hs_single_chk: assert property (@(posedge clk) disable iff (rst)
    hs_start |=> !hs_start);
  // R4
  hs_after_bridge_chk: assert property (@(posedge clk) disable iff (rst)
    hs_start |-> ($past(filt) == LS_BRIDGE));
  // R5
  esc_after_bridge_chk: assert property (@(posedge clk) disable iff (rst)
    esc_start |-> ($past(filt) == LS_BRIDGE));
  // R7
  err_clears_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_err) |-> stop_pulse);
  // R8
  stop_after_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> ($past(filt) == LS_STOP));
  // R3
  conf_chg_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(conf && chg));
endmodule

// File: rtl/lp_lane_monitor.sv
module lp_lane_monitor import lpmon_pkg::*; #(
  parameter int TLPX_CYC = 5,
  parameter int GW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lp_p,
  input  logic          lp_n,
  input  logic [GW-1:0] glitch_len,
  output logic [1:0]    line_state,
  output logic          hs_start,
  output logic          esc_start,
  output logic          stop_pulse,
  output logic          seq_err
);
  lp_state_t filt;
  logic upd, chg, conf;

  lpmon_filter #(.GW(GW)) u_filt (
    .clk(clk), .rst(rst), .raw({lp_p, lp_n}), .glitch_len(glitch_len),
    .filt(filt), .upd(upd), .chg(chg)
  );

  lpmon_dwell #(.TLPX_CYC(TLPX_CYC)) u_dwell (
    .clk(clk), .rst(rst), .upd(upd), .conf(conf)
  );

  lpmon_seq u_seq (
    .clk(clk), .rst(rst), .filt(filt), .chg(chg), .conf(conf),
    .hs_start(hs_start), .esc_start(esc_start),
    .stop_pulse(stop_pulse), .seq_err(seq_err)
  );

  assign line_state = filt;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (line_state == 2'b11 && !seq_err && !hs_start && !esc_start));
endmodule

// File: tb/sim_lp_lane_monitor.sv
module sim_lp_lane_monitor;
  localparam int PERIOD = 10;
  localparam int TLPX = 4;
  localparam int GW = 4;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0]  st;
    logic [31:0] hold;
    logic [1:0]  hs;
    logic [1:0]  esc;
    logic [1:0]  stp;
    logic        err;
  } vec_t;

  // states {s0,s1,s2,s3}, holds {h0,h1,h2,h3}, expected hs/esc/stop counts, error seen
  localparam vec_t VEC [NV] = '{
    '{8'b01_00_10_00, {8'd6, 8'd6, 8'd5, 8'd3}, 2'd1, 2'd0, 2'd1, 1'b0}, // R4 R8
    '{8'b10_00_01_00, {8'd6, 8'd6, 8'd5, 8'd3}, 2'd0, 2'd1, 2'd1, 1'b0}, // R5 R9
    '{8'b01_00_00_00, {8'd3, 8'd6, 8'd6, 8'd0}, 2'd0, 2'd0, 2'd1, 1'b1}, // R3 R6
    '{8'b00_10_00_00, {8'd6, 8'd6, 8'd0, 8'd0}, 2'd0, 2'd0, 2'd1, 1'b1}, // R6 R7
    '{8'b01_11_00_00, {8'd1, 8'd6, 8'd0, 8'd0}, 2'd0, 2'd0, 2'd0, 1'b0}, // R2
    '{8'b01_11_00_00, {8'd6, 8'd8, 8'd0, 8'd0}, 2'd0, 2'd0, 2'd1, 1'b1}, // R6
    '{8'b10_01_00_00, {8'd6, 8'd6, 8'd0, 8'd0}, 2'd0, 2'd0, 2'd1, 1'b1}, // R6
    '{8'b01_00_11_00, {8'd6, 8'd2, 8'd8, 8'd0}, 2'd0, 2'd0, 2'd1, 1'b1}, // R6
    '{8'b01_11_01_00, {8'd3, 8'd1, 8'd3, 8'd6}, 2'd1, 2'd0, 2'd1, 1'b0}, // R2 R4
    '{8'b01_00_00_00, {8'd4, 8'd4, 8'd0, 8'd0}, 2'd1, 2'd0, 2'd1, 1'b0}  // R3 R4
  };

  logic clk = 1'b0, rst = 1'b1, lp_p = 1'b1, lp_n = 1'b1;
  logic [GW-1:0] glitch_len = GW'(1);
  logic [1:0] line_state;
  logic hs_start, esc_start, stop_pulse, seq_err;

  int checks = 0, errors = 0;
  int n_hs = 0, n_esc = 0, n_stop = 0, n_err = 0;

  always #(PERIOD/2) clk = ~clk;

  lp_lane_monitor #(.TLPX_CYC(TLPX), .GW(GW)) u0 (
    .clk(clk), .rst(rst), .lp_p(lp_p), .lp_n(lp_n), .glitch_len(glitch_len),
    .line_state(line_state), .hs_start(hs_start), .esc_start(esc_start),
    .stop_pulse(stop_pulse), .seq_err(seq_err)
  );

  always @(posedge clk) if (!rst) begin
    n_hs   <= n_hs + int'(hs_start);
    n_esc  <= n_esc + int'(esc_start);
    n_stop <= n_stop + int'(stop_pulse);
    n_err  <= n_err + int'(seq_err);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input int h);
    {lp_p, lp_n} = s;
    repeat (h) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b_hs, b_esc, b_stop, b_err, k;
    logic saw;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(line_state == 2'b11, "R1 line_state", line_state, 3);
    chk(!hs_start && !esc_start, "R1 start pulses", hs_start + esc_start, 0);
    chk(!stop_pulse, "R1 stop_pulse", stop_pulse, 0);
    chk(!seq_err, "R1 seq_err", seq_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(line_state == 2'b11 && !seq_err, "R1 after release", line_state, 3);
    repeat (12) @(negedge clk);
    chk(n_stop == 1, "R1 initial stop", n_stop, 1);

    // R2 / R11: one edge of 10 is rejected with glitch_len 1, second is accepted
    drive(2'b10, 1);
    chk(line_state == 2'b11, "R2 held back", line_state, 3);
    drive(2'b10, 1);
    chk(line_state == 2'b10, "R11 line_state shows 10", line_state, 2);
    drive(2'b10, 6);
    drive(2'b11, 14);

    for (int v = 0; v < NV; v++) begin
      b_hs = n_hs; b_esc = n_esc; b_stop = n_stop; b_err = n_err;
      for (int s = 0; s < 4; s++)
        drive(VEC[v].st[7-2*s -: 2], int'(VEC[v].hold[31-8*s -: 8]));
      drive(2'b11, 14);
      chk(n_hs - b_hs == int'(VEC[v].hs), $sformatf("R4 vec%0d hs_start", v), n_hs - b_hs, VEC[v].hs);
      chk(n_esc - b_esc == int'(VEC[v].esc), $sformatf("R5 vec%0d esc_start", v), n_esc - b_esc, VEC[v].esc);
      chk(n_stop - b_stop == int'(VEC[v].stp), $sformatf("R8 vec%0d stop_pulse", v), n_stop - b_stop, VEC[v].stp);
      chk((n_err != b_err) == VEC[v].err, $sformatf("R6 vec%0d seq_err", v), int'(n_err != b_err), VEC[v].err);
      chk(!seq_err, $sformatf("R7 vec%0d cleared", v), seq_err, 0);
    end

    // R4 exact latency and R10 width: G=1, TLPX=4, pulse after edge 5
    drive(2'b01, 6);
    {lp_p, lp_n} = 2'b00;
    repeat (1 + TLPX) @(posedge clk);
    @(negedge clk);
    chk(!hs_start, "R4 not early", hs_start, 0);
    @(negedge clk);
    chk(hs_start, "R4 on time", hs_start, 1);
    @(negedge clk);
    chk(!hs_start, "R10 one cycle", hs_start, 0);
    drive(2'b00, 4);
    drive(2'b11, 14);

    // R6 / R7: Bridge straight from Stop, then recovery
    drive(2'b00, 10);
    chk(seq_err, "R6 bridge from stop", seq_err, 1);
    {lp_p, lp_n} = 2'b11;
    saw = 1'b0;
    k = 0;
    while (!saw && k < 20) begin
      @(negedge clk);
      k++;
      if (stop_pulse) saw = 1'b1;
      else chk(seq_err, "R7 held until stop", seq_err, 1);
    end
    chk(saw, "R7 stop seen", saw, 1);
    chk(!seq_err, "R7 cleared with stop", seq_err, 0);
    drive(2'b11, 6);

    // R2 with glitch_len 0: a single-cycle request is accepted and then breaks order
    glitch_len = '0;
    b_err = n_err;
    drive(2'b01, 1);
    drive(2'b11, 14);
    chk(n_err != b_err, "R2 zero filter accepts one cycle", int'(n_err != b_err), 1);
    glitch_len = GW'(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule